// File: doc/BRIEF.md
# Load/Store Ordering Queue

This block keeps every load and store in program order from dispatch until retirement. It decides when each load may go to the data cache and when each store may write memory. An entry is allocated at the tail when the instruction dispatches. Its word address arrives later, once address generation has finished. A load is sent to the cache only when no older store could still write the word it reads: every older store must have a known address, and that address must differ from the load's. A store writes memory only when the commit logic marks it as the oldest instruction that can no longer be undone.

Each slot runs a small state machine:

| State | Meaning |
|---|---|
| `E_FREE` | Slot is unused. |
| `E_WAIT` | Slot is allocated and its address is unknown. |
| `E_READY` | Address is known. A load here has not issued yet; a store here waits for commit. |
| `E_DONE` | Load has issued. |

| Transition | Change | Condition |
|---|---|---|
| ALLOC | `E_FREE`→`E_WAIT` | Slot is at the tail and is allocated. |
| FILL | `E_WAIT`→`E_READY` | The address for the slot arrives. |
| ISSUE | `E_READY`→`E_DONE` | Load only; the slot is picked for the cache. |
| RELEASE | `E_READY`→`E_FREE` (store) or `E_DONE`→`E_FREE` (load) | Commit at the head. |
| SQUASH | any state→`E_FREE` | A flush covers the slot; this has priority over all other transitions. |

The queue is a circular buffer with head and tail pointers and an occupancy count. Retirement frees the head. A flush names a slot and discards that slot and everything younger, so the tail moves back to it. Addresses are compared as full-width word addresses for equality.

Top module: `lsq_dep_check`

## Requirements
- R1: After reset:
  - the queue is empty (`empty`=1, `full`=0);
  - `alloc_idx` is 0;
  - `ld_issue_valid`, `st_wr_valid` and `retire_valid` are all 0.
- R2: Allocation:
  - An accepted allocation takes the slot shown on `alloc_idx`, and `alloc_idx` then advances by one.
  - `full` rises once DEPTH entries are held.
  - An allocation request while full is ignored, and `alloc_idx` does not move.
- R3: An address is accepted only by a slot in `E_WAIT`. A second address for the same slot is ignored, and the first address is the one later used for ordering and for the store write.
- R4: A load with a known address is held while any older store has an unknown address. The load issues in the cycle after the last such store receives its address, driving its slot index and address.
- R5: A load is held while an older store with a known address has exactly the same word address. A load whose address differs from that store in a single bit is not held.
- R6: Issue selection:
  - Younger stores never hold a load.
  - At most one load issues per cycle, and when several are eligible the oldest issues first.
  - Each load issues exactly once.
- R7: When `commit_valid` is high and the head slot is a store with a known address, `st_wr_valid` is 1 with that address in the same cycle, `retire_valid` is 1, and the slot is freed.
- R8: Commit of the head:
  - A load at the head retires on `commit_valid` only after it has issued.
  - A commit is ignored (`retire_valid`=0) when the queue is empty, the head store has no address, or the head load has not issued.
- R9: Flush:
  - A flush naming an occupied slot frees that slot and every younger one, and `alloc_idx` becomes the flushed slot.
  - A flush naming an unoccupied slot is ignored.
  - In a flush cycle, allocation, commit and load issue are all suppressed.
  - A flushed load never issues.
- R10: Slot indices wrap from DEPTH-1 back to 0 for allocation, retirement and age ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_is_store | input | 1 | 1 for a store, 0 for a load |
| alloc_idx | output | IW | Slot the next allocation takes |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| addr_valid | input | 1 | Address fill strobe |
| addr_idx | input | IW | Slot receiving the address |
| addr_value | input | AW | Word address |
| ld_issue_valid | output | 1 | A load is sent to the cache this cycle |
| ld_issue_idx | output | IW | Slot of the issuing load |
| ld_issue_addr | output | AW | Address of the issuing load |
| commit_valid | input | 1 | Head instruction is non-speculative |
| st_wr_valid | output | 1 | Store writes memory this cycle |
| st_wr_addr | output | AW | Address of that store |
| retire_valid | output | 1 | Head slot is freed this cycle |
| flush_valid | input | 1 | Discard from `flush_idx` to the tail |
| flush_idx | input | IW | Oldest slot to discard |

## Verification
The bench pursues these corner cases:

- **Loads held by older stores.** A load sits behind an older store whose address is still unknown, and behind an older store with the same address. A design that ignored unknown addresses, or compared only part of the word, would issue early; the scoreboard reports that as an unexpected load.
- **Address rewrite and younger stores.** A second address is sent to a store, and a younger store with a matching address is placed after two waiting loads. A design that accepted the rewrite, or that let younger stores block, would release the wrong load or none at all.
- **Full queue, wrap and flush.** The bench fills the queue across the index wrap and allocates while full. It then flushes with allocation and commit raised in the same cycle, and flushes a slot that is not occupied. A pointer error shows as a wrong `alloc_idx`, a spurious store write, or a flushed load that issues once its blocking store retires.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [1:0] {
        E_FREE  = 2'd0,
        E_WAIT  = 2'd1,
        E_READY = 2'd2,
        E_DONE  = 2'd3
    } ent_state_e;

    // distance of a slot from the head in program order
    function automatic int age_of(input int idx, input int head, input int depth);
        return (idx >= head) ? (idx - head) : (idx + depth - head);
    endfunction

endpackage

// File: rtl/lsq_entry.sv
module lsq_entry
    import lsq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic          alloc_store,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_addr,
    input  logic          issue_en,
    input  logic          release_en,
    input  logic          squash_en,
    output ent_state_e    state,
    output logic          is_store,
    output logic [AW-1:0] addr,
    output logic          ld_ready,
    output logic          st_open,
    output logic          st_known,
    output logic          can_retire
);

    ent_state_e    state_q, state_d;
    logic          store_q;
    logic [AW-1:0] addr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= E_FREE;
        else        state_q <= state_d;
    end

    // next-state logic: ALLOC, FILL, ISSUE, RELEASE, SQUASH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_FREE:  if (alloc_en) state_d = E_WAIT;
            E_WAIT:  if (fill_en)  state_d = E_READY;
            E_READY: begin
                if (issue_en && !store_q)        state_d = E_DONE;
                else if (release_en && store_q)  state_d = E_FREE;
            end
            E_DONE:  if (release_en) state_d = E_FREE;
        endcase
        if (squash_en) state_d = E_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            if (state_q == E_FREE && alloc_en) store_q <= alloc_store;
            if (state_q == E_WAIT && fill_en)  addr_q  <= fill_addr;
        end
    end

    // outputs
    always_comb begin
        state      = state_q;
        is_store   = store_q;
        addr       = addr_q;
        ld_ready   = (state_q == E_READY) && !store_q;
        st_open    = (state_q == E_WAIT)  && store_q;
        st_known   = (state_q == E_READY) && store_q;
        can_retire = store_q ? (state_q == E_READY) : (state_q == E_DONE);
    end

    // R6
    issue_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == E_DONE) |-> $past(state_q) == E_READY);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_READY && $past(state_q) == E_READY) |-> $stable(addr_q));

endmodule

// File: rtl/lsq_ptrs.sv
module lsq_ptrs
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_fire,
    input  logic          retire_fire,
    input  logic          flush_fire,
    input  logic [IW-1:0] flush_idx,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic [CW-1:0] count
);

    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (flush_fire) begin
            tail_q  <= flush_idx;
            count_q <= CW'(age_of(int'(flush_idx), int'(head_q), DEPTH));
        end else begin
            if (alloc_fire)  tail_q <= bump(tail_q);
            if (retire_fire) head_q <= bump(head_q);
            unique case ({alloc_fire, retire_fire})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head  = head_q;
    assign tail  = tail_q;
    assign count = count_q;

    // R2
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= DEPTH);

    // R10
    ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tail_q) == (int'(head_q) + int'(count_q)) % DEPTH);

endmodule

// File: rtl/lsq_pick.sv
module lsq_pick
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int IW    = 3
) (
    input  logic [IW-1:0]    head,
    input  logic [DEPTH-1:0] ld_ready,
    input  logic [DEPTH-1:0] st_open,
    input  logic [DEPTH-1:0] st_known,
    input  logic [AW-1:0]    addr [DEPTH],
    output logic             pick_valid,
    output logic [IW-1:0]    pick_idx
);

    logic [DEPTH-1:0] ld_clear;

    // a load is clear when no older store is unknown or aliases it
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ld_clear[i] = ld_ready[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i &&
                    age_of(j, int'(head), DEPTH) < age_of(i, int'(head), DEPTH) &&
                    (st_open[j] || (st_known[j] && addr[j] == addr[i])))
                    ld_clear[i] = 1'b0;
            end
        end
    end

    // oldest clear load wins
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int o = 0; o < DEPTH; o++) begin
            int k;
            k = int'(head) + o;
            if (k >= DEPTH) k = k - DEPTH;
            if (!pick_valid && ld_clear[k]) begin
                pick_valid = 1'b1;
                pick_idx   = IW'(k);
            end
        end
    end

endmodule

// File: rtl/lsq_dep_check.sv
module lsq_dep_check
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_is_store,
    output logic [IW-1:0] alloc_idx,
    output logic          full,
    output logic          empty,
    input  logic          addr_valid,
    input  logic [IW-1:0] addr_idx,
    input  logic [AW-1:0] addr_value,
    output logic          ld_issue_valid,
    output logic [IW-1:0] ld_issue_idx,
    output logic [AW-1:0] ld_issue_addr,
    input  logic          commit_valid,
    output logic          st_wr_valid,
    output logic [AW-1:0] st_wr_addr,
    output logic          retire_valid,
    input  logic          flush_valid,
    input  logic [IW-1:0] flush_idx
);

    logic [IW-1:0]    head_q, tail_q;
    logic [CW-1:0]    count_q;
    logic             alloc_fire, retire_ok, flush_ok;
    logic             pick_valid;
    logic [IW-1:0]    pick_idx;

    ent_state_e       ent_st     [DEPTH];
    logic [AW-1:0]    ent_addr   [DEPTH];
    logic [DEPTH-1:0] ent_store, ent_ld_ready, ent_st_open, ent_st_known, ent_retire;

    assign full       = (int'(count_q) == DEPTH);
    assign empty      = (count_q == '0);
    assign alloc_fire = alloc_valid && !full && !flush_valid;
    assign flush_ok   = flush_valid &&
                        (age_of(int'(flush_idx), int'(head_q), DEPTH) < int'(count_q));
    assign retire_ok  = commit_valid && !flush_valid && !empty && ent_retire[head_q];

    lsq_ptrs #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .retire_fire (retire_ok),
        .flush_fire  (flush_ok),
        .flush_idx   (flush_idx),
        .head        (head_q),
        .tail        (tail_q),
        .count       (count_q)
    );

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            logic squash_g;
            assign squash_g = flush_ok &&
                (age_of(g, int'(head_q), DEPTH) >= age_of(int'(flush_idx), int'(head_q), DEPTH)) &&
                (age_of(g, int'(head_q), DEPTH) < int'(count_q));

            lsq_entry #(.AW(AW)) u_ent (
                .clk         (clk),
                .rst_n       (rst_n),
                .alloc_en    (alloc_fire && tail_q == IW'(g)),
                .alloc_store (alloc_is_store),
                .fill_en     (addr_valid && addr_idx == IW'(g)),
                .fill_addr   (addr_value),
                .issue_en    (ld_issue_valid && ld_issue_idx == IW'(g)),
                .release_en  (retire_ok && head_q == IW'(g)),
                .squash_en   (squash_g),
                .state       (ent_st[g]),
                .is_store    (ent_store[g]),
                .addr        (ent_addr[g]),
                .ld_ready    (ent_ld_ready[g]),
                .st_open     (ent_st_open[g]),
                .st_known    (ent_st_known[g]),
                .can_retire  (ent_retire[g])
            );
        end
    endgenerate

    lsq_pick #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_pick (
        .head       (head_q),
        .ld_ready   (ent_ld_ready),
        .st_open    (ent_st_open),
        .st_known   (ent_st_known),
        .addr       (ent_addr),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    always_comb begin
        alloc_idx      = tail_q;
        ld_issue_valid = pick_valid && !flush_valid;
        ld_issue_idx   = pick_idx;
        ld_issue_addr  = ent_addr[pick_idx];
        retire_valid   = retire_ok;
        st_wr_valid    = retire_ok && ent_store[head_q];
        st_wr_addr     = ent_addr[head_q];
    end

    // R7
    st_wr_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_valid |=> head_q != $past(head_q));

    // R4
    ld_issue_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_issue_valid |=> ent_st[$past(ld_issue_idx)] == E_DONE);

endmodule

// File: tb/lsq_dep_check_test.sv
module lsq_dep_check_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid, alloc_is_store;
    logic [2:0]  alloc_idx;
    logic        full, empty;
    logic        addr_valid;
    logic [2:0]  addr_idx;
    logic [31:0] addr_value;
    logic        ld_issue_valid;
    logic [2:0]  ld_issue_idx;
    logic [31:0] ld_issue_addr;
    logic        commit_valid;
    logic        st_wr_valid;
    logic [31:0] st_wr_addr;
    logic        retire_valid;
    logic        flush_valid;
    logic [2:0]  flush_idx;

    int checks = 0;
    int errors = 0;
    int          exp_ld_idx  [$];
    logic [31:0] exp_ld_addr [$];
    logic [31:0] exp_st      [$];
    logic        obs_retire;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsq_dep_check uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic a_v, input logic a_s, input logic f_v, input logic [2:0] f_i,
                       input logic [31:0] f_a, input logic c_v, input logic fl_v, input logic [2:0] fl_i);
        @(posedge clk); #1;
        alloc_valid = a_v; alloc_is_store = a_s;
        addr_valid = f_v; addr_idx = f_i; addr_value = f_a;
        commit_valid = c_v; flush_valid = fl_v; flush_idx = fl_i;
        @(negedge clk);
        obs_retire = retire_valid;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic alloc(input logic s); cyc(1, s, 0, 0, 0, 0, 0, 0); endtask
    task automatic fill(input logic [2:0] i, input logic [31:0] a); cyc(0, 0, 1, i, a, 0, 0, 0); endtask
    task automatic commit(); cyc(0, 0, 0, 0, 0, 1, 0, 0); endtask
    task automatic push_ld(input int i, input logic [31:0] a);
        exp_ld_idx.push_back(i); exp_ld_addr.push_back(a);
    endtask

    // monitor: scoreboard pops expected issues and store writes
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (ld_issue_valid) begin
                if (exp_ld_idx.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4/R5/R6/R9 unexpected load issue actual idx %0d expected none", ld_issue_idx);
                end else begin
                    chk("R6 issue idx", 32'(ld_issue_idx), 32'(exp_ld_idx.pop_front()));
                    chk("R4 issue addr", ld_issue_addr, exp_ld_addr.pop_front());
                end
            end
            if (st_wr_valid) begin
                if (exp_st.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7/R9 unexpected store write actual %0h expected none", st_wr_addr);
                end else chk("R7 store addr", st_wr_addr, exp_st.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; alloc_valid = 0; alloc_is_store = 0; addr_valid = 0; addr_idx = 0;
        addr_value = 0; commit_valid = 0; flush_valid = 0; flush_idx = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 empty", 32'(empty), 1); chk("R1 full", 32'(full), 0);
        chk("R1 alloc_idx", 32'(alloc_idx), 0); chk("R1 issue", 32'(ld_issue_valid), 0);
        chk("R1 st_wr", 32'(st_wr_valid), 0); chk("R1 retire", 32'(retire_valid), 0);

        alloc(1); alloc(0); idle(1);                      // S0, L1
        chk("R2 alloc_idx", 32'(alloc_idx), 2); chk("R2 empty", 32'(empty), 0);
        fill(1, 32'h100); idle(2);                        // R4: held by unknown S0
        push_ld(1, 32'h100); fill(0, 32'h200); idle(2);   // R4: released
        fill(0, 32'h100);                                 // R3: ignored
        alloc(0); fill(2, 32'h200); idle(2);              // R5: L2 held by equal addr
        push_ld(3, 32'h201); alloc(0); fill(3, 32'h201); idle(2); // R5: one bit apart
        exp_st.push_back(32'h200); push_ld(2, 32'h200);
        commit(); chk("R7 retire store", 32'(obs_retire), 1);
        idle(2);
        commit(); chk("R8 retire load", 32'(obs_retire), 1);
        commit(); chk("R8 retire load2", 32'(obs_retire), 1);
        alloc(1);                                         // S4
        commit(); chk("R8 retire load3", 32'(obs_retire), 1);
        commit(); chk("R8 ignored commit", 32'(obs_retire), 0);
        idle(1); chk("R8 not empty", 32'(empty), 0);

        alloc(0); alloc(0); alloc(1);                     // L5, L6, S7
        fill(6, 32'h300); fill(5, 32'h300); fill(7, 32'h300); idle(2);
        push_ld(5, 32'h300); push_ld(6, 32'h300);         // R6: oldest first, younger S7 no block
        fill(4, 32'h400); idle(3);
        chk("R6 all issued", 32'(exp_ld_idx.size()), 0);

        chk("R10 wrap alloc_idx", 32'(alloc_idx), 0);
        for (int i = 0; i < 4; i++) alloc(0);             // L0..L3
        idle(1); chk("R2 full", 32'(full), 1);
        alloc(0); idle(1); chk("R2 ignored alloc", 32'(alloc_idx), 4);
        push_ld(0, 32'h500); fill(0, 32'h500); idle(2);   // R10: wrapped ordering
        fill(1, 32'h300); idle(2);                        // held by S7
        cyc(1, 0, 0, 0, 0, 1, 1, 1);                      // R9 flush with alloc and commit
        chk("R9 commit suppressed", 32'(obs_retire), 0);
        idle(1); chk("R9 tail", 32'(alloc_idx), 1); chk("R9 not full", 32'(full), 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 2);                      // R9 out-of-range flush
        idle(1); chk("R9 ignored flush", 32'(alloc_idx), 1);

        exp_st.push_back(32'h400);
        commit(); chk("R7 retire S4", 32'(obs_retire), 1);
        commit(); commit();
        exp_st.push_back(32'h300);
        commit(); chk("R7 retire S7", 32'(obs_retire), 1);
        idle(2);                                          // R9: flushed L1 must stay silent
        commit(); chk("R8 retire L0", 32'(obs_retire), 1);
        idle(1); chk("R9 empty", 32'(empty), 1);
        chk("R4 pending loads", 32'(exp_ld_idx.size()), 0);
        chk("R7 pending stores", 32'(exp_st.size()), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule